// File: doc/BRIEF.md
# Per-CPU Interrupt Presentation Controller

This block holds the interrupt presentation state of a single processor. It keeps a 32-bit presentation word. The upper byte of that word is the processor's current priority and the lower 24 bits are the number of the pending source. Beside the word it keeps the priority of the pending source and the priority of an inter-processor interrupt (IPI) request. A lower priority value is more favoured. A source number of zero means that nothing is pending.

A source controller offers interrupts on a delivery port as a source number plus a priority. The block keeps the most favoured candidate and returns every losing source number on a reject port. It raises an interrupt line to the processor while a source is installed. The processor side issues one command per cycle: set processor priority, set IPI priority, accept, or end-of-interrupt. Commands take precedence over a delivery offered in the same cycle, and the block holds off that delivery with a ready signal. Toward the source controller the block drives single-cycle pulses for reject, end-of-interrupt and resend. The IPI uses a reserved source number and competes with external sources by priority.

Top module: `irq_present_ctrl`

## Requirements
- R1: After reset the interrupt line is low, no pulse output is active, the presentation word is zero, and the pending and IPI priorities are 0xFF. A first accept therefore returns 0x00000000 and a second one returns 0xFF000000.
- R2: A delivery (src_valid_i while src_ready_o is high) is rejected if its priority is greater than or equal to the processor priority. It is also rejected if a source is pending whose pending priority is less than or equal to the incoming one. A rejected delivery pulses rej_valid_o with the incoming number in the next cycle and changes no state.
- R3: A delivery that is not rejected installs its number and priority and drives irq_o high from the next cycle. If it displaces a pending source, that source's number is pulsed on the reject port in the same cycle.
- R4: An accept (cmd_op_i = 2) pulses acc_valid_o in the next cycle with acc_data_o equal to the whole presentation word {processor priority, source number}, and drives irq_o low. The processor priority then takes the pending priority and the source number becomes zero.
- R5: A set-priority command (cmd_op_i = 0, value in cmd_data_i[7:0]) with a value lower than the current processor priority always stores that value. If a source is pending and the value is less than or equal to the pending priority, the source number is cleared, irq_o goes low and the number is pulsed on the reject port.
- R6: A set-priority command whose value is greater than or equal to the current processor priority stores it. If nothing is pending, a resend follows: when the IPI priority is below the new processor priority the IPI is installed and irq_o rises, and in every case resend_o pulses once.
- R7: An end-of-interrupt command (cmd_op_i = 3) copies cmd_data_i[31:24] into the processor priority and pulses eoi_valid_o with eoi_num_o = cmd_data_i[23:0]. If nothing is pending it then performs the resend of R6 using the new processor priority.
- R8: A set-IPI command (cmd_op_i = 1, value in cmd_data_i[7:0]) stores the IPI priority. If the value is below the processor priority and no pending source has a pending priority less than or equal to it, the block installs the reserved number IPI_NUM (default 2) with that priority and raises irq_o. Any displaced source is pulsed on the reject port.
- R9: While cmd_valid_i is high, src_ready_o is low and a delivery offered in that cycle has no effect: no reject, and no change to the presentation word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| src_valid_i | input | 1 | Delivery offered |
| src_num_i | input | 24 | Offered source number |
| src_prio_i | input | 8 | Offered source priority |
| src_ready_o | output | 1 | Delivery taken this cycle |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_op_i | input | 2 | 0 set priority, 1 set IPI, 2 accept, 3 end-of-interrupt |
| cmd_data_i | input | 32 | Command operand |
| acc_valid_o | output | 1 | Accept result pulse |
| acc_data_o | output | 32 | Presentation word returned by accept |
| irq_o | output | 1 | Interrupt line to the processor |
| rej_valid_o | output | 1 | Reject pulse |
| rej_num_o | output | 24 | Rejected source number |
| eoi_valid_o | output | 1 | End-of-interrupt pulse |
| eoi_num_o | output | 24 | Completed source number |
| resend_o | output | 1 | Resend request pulse |

## Verification
All results are registered. Reject, end-of-interrupt, resend and accept pulses, and any change of irq_o, appear in the cycle after the edge that samples the command or delivery. src_ready_o follows cmd_valid_i within the same cycle. The bench drives inputs on the falling edge and checks src_ready_o shortly afterwards. It then compares every output just after the next rising edge against a reference model that has advanced by exactly one operation. Pulses are therefore seen in the one cycle they may be high, and an unexpected pulse in any other cycle counts as a mismatch.

// File: rtl/ipc_pkg.sv
package ipc_pkg;
  typedef enum logic [1:0] {
    OP_SET_CPPR = 2'd0,
    OP_SET_IPI  = 2'd1,
    OP_ACCEPT   = 2'd2,
    OP_EOI      = 2'd3
  } ipc_op_e;
endpackage

// File: rtl/ipc_src_arb.sv
// Decides whether an offered source beats the currently installed one.
module ipc_src_arb #(
  parameter int SRC_W  = 24,
  parameter int PRIO_W = 8
) (
  input  logic [PRIO_W-1:0] cppr_i,
  input  logic [SRC_W-1:0]  xisr_i,
  input  logic [PRIO_W-1:0] pend_i,
  input  logic [SRC_W-1:0]  in_num_i,
  input  logic [PRIO_W-1:0] in_prio_i,
  output logic              take_o,
  output logic              rej_o,
  output logic [SRC_W-1:0]  rej_num_o
);
  logic busy, lose;
  always_comb begin
    busy      = (xisr_i != '0);
    lose      = (in_prio_i >= cppr_i) || (busy && (pend_i <= in_prio_i));
    take_o    = !lose;
    rej_o     = lose || busy;
    rej_num_o = lose ? in_num_i : xisr_i;
  end
endmodule

// File: rtl/ipc_ipi_check.sv
// IPI check: install unless an equal-or-better source is pending.
module ipc_ipi_check #(
  parameter int SRC_W  = 24,
  parameter int PRIO_W = 8
) (
  input  logic [SRC_W-1:0]  xisr_i,
  input  logic [PRIO_W-1:0] pend_i,
  input  logic [PRIO_W-1:0] mfrr_i,
  output logic              take_o,
  output logic              rej_o,
  output logic [SRC_W-1:0]  rej_num_o
);
  logic busy;
  always_comb begin
    busy      = (xisr_i != '0);
    take_o    = !(busy && (pend_i <= mfrr_i));
    rej_o     = take_o && busy;
    rej_num_o = xisr_i;
  end
endmodule

// File: rtl/ipc_next_state.sv
module ipc_next_state
  import ipc_pkg::*;
#(
  parameter int SRC_W   = 24,
  parameter int PRIO_W  = 8,
  parameter int IPI_NUM = 2
) (
  input  logic                    cmd_valid_i,
  input  ipc_op_e                 cmd_op_i,
  input  logic [PRIO_W+SRC_W-1:0] cmd_data_i,
  input  logic                    src_valid_i,
  input  logic [SRC_W-1:0]        src_num_i,
  input  logic [PRIO_W-1:0]       src_prio_i,
  input  logic [PRIO_W-1:0]       cppr_i,
  input  logic [SRC_W-1:0]        xisr_i,
  input  logic [PRIO_W-1:0]       pend_i,
  input  logic [PRIO_W-1:0]       mfrr_i,
  input  logic                    irq_i,
  output logic [PRIO_W-1:0]       cppr_o,
  output logic [SRC_W-1:0]        xisr_o,
  output logic [PRIO_W-1:0]       pend_o,
  output logic [PRIO_W-1:0]       mfrr_o,
  output logic                    irq_o,
  output logic                    rej_v_o,
  output logic [SRC_W-1:0]        rej_num_o,
  output logic                    eoi_v_o,
  output logic [SRC_W-1:0]        eoi_num_o,
  output logic                    resend_o,
  output logic                    acc_v_o,
  output logic [PRIO_W+SRC_W-1:0] acc_data_o
);
  localparam int REG_W = PRIO_W + SRC_W;
  localparam logic [SRC_W-1:0] IPI_ID = SRC_W'(IPI_NUM);

  logic              busy;
  logic [PRIO_W-1:0] op_prio;
  logic [PRIO_W-1:0] cppr_after;

  // delivery arbitration
  logic              arb_take, arb_rej;
  logic [SRC_W-1:0]  arb_rej_num;
  ipc_src_arb #(.SRC_W(SRC_W), .PRIO_W(PRIO_W)) u_arb (
    .cppr_i   (cppr_i),
    .xisr_i   (xisr_i),
    .pend_i   (pend_i),
    .in_num_i (src_num_i),
    .in_prio_i(src_prio_i),
    .take_o   (arb_take),
    .rej_o    (arb_rej),
    .rej_num_o(arb_rej_num)
  );

  // IPI check for a new IPI priority
  logic              ipw_take, ipw_rej;
  logic [SRC_W-1:0]  ipw_rej_num;
  ipc_ipi_check #(.SRC_W(SRC_W), .PRIO_W(PRIO_W)) u_ipi_wr (
    .xisr_i   (xisr_i),
    .pend_i   (pend_i),
    .mfrr_i   (op_prio),
    .take_o   (ipw_take),
    .rej_o    (ipw_rej),
    .rej_num_o(ipw_rej_num)
  );

  // IPI check inside a resend (stored IPI priority)
  logic              irs_take, irs_rej;
  logic [SRC_W-1:0]  irs_rej_num;
  ipc_ipi_check #(.SRC_W(SRC_W), .PRIO_W(PRIO_W)) u_ipi_rs (
    .xisr_i   (xisr_i),
    .pend_i   (pend_i),
    .mfrr_i   (mfrr_i),
    .take_o   (irs_take),
    .rej_o    (irs_rej),
    .rej_num_o(irs_rej_num)
  );

  always_comb begin
    busy       = (xisr_i != '0);
    op_prio    = cmd_data_i[PRIO_W-1:0];
    cppr_after = (cmd_op_i == OP_EOI) ? cmd_data_i[REG_W-1:SRC_W] : op_prio;

    cppr_o     = cppr_i;
    xisr_o     = xisr_i;
    pend_o     = pend_i;
    mfrr_o     = mfrr_i;
    irq_o      = irq_i;
    rej_v_o    = 1'b0;
    rej_num_o  = '0;
    eoi_v_o    = 1'b0;
    eoi_num_o  = '0;
    resend_o   = 1'b0;
    acc_v_o    = 1'b0;
    acc_data_o = '0;

    if (cmd_valid_i) begin
      unique case (cmd_op_i)
        OP_SET_CPPR: begin
          cppr_o = op_prio;
          if (op_prio < cppr_i) begin
            if (busy && (op_prio <= pend_i)) begin
              xisr_o    = '0;
              irq_o     = 1'b0;
              rej_v_o   = 1'b1;
              rej_num_o = xisr_i;
            end
          end else if (!busy) begin
            resend_o = 1'b1;
            if ((mfrr_i < cppr_after) && irs_take) begin
              rej_v_o   = irs_rej;
              rej_num_o = irs_rej ? irs_rej_num : '0;
              xisr_o    = IPI_ID;
              pend_o    = mfrr_i;
              irq_o     = 1'b1;
            end
          end
        end
        OP_SET_IPI: begin
          mfrr_o = op_prio;
          if ((op_prio < cppr_i) && ipw_take) begin
            rej_v_o   = ipw_rej;
            rej_num_o = ipw_rej ? ipw_rej_num : '0;
            xisr_o    = IPI_ID;
            pend_o    = op_prio;
            irq_o     = 1'b1;
          end
        end
        OP_ACCEPT: begin
          acc_v_o    = 1'b1;
          acc_data_o = {cppr_i, xisr_i};
          irq_o      = 1'b0;
          cppr_o     = pend_i;
          xisr_o     = '0;
        end
        OP_EOI: begin
          cppr_o    = cppr_after;
          eoi_v_o   = 1'b1;
          eoi_num_o = cmd_data_i[SRC_W-1:0];
          if (!busy) begin
            resend_o = 1'b1;
            if ((mfrr_i < cppr_after) && irs_take) begin
              xisr_o = IPI_ID;
              pend_o = mfrr_i;
              irq_o  = 1'b1;
            end
          end
        end
        default: ;
      endcase
    end else if (src_valid_i) begin
      rej_v_o   = arb_rej;
      rej_num_o = arb_rej_num;
      if (arb_take) begin
        xisr_o = src_num_i;
        pend_o = src_prio_i;
        irq_o  = 1'b1;
      end
    end
  end
endmodule

// File: rtl/irq_present_ctrl.sv
module irq_present_ctrl
  import ipc_pkg::*;
#(
  parameter int SRC_W   = 24,
  parameter int PRIO_W  = 8,
  parameter int IPI_NUM = 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    src_valid_i,
  input  logic [SRC_W-1:0]        src_num_i,
  input  logic [PRIO_W-1:0]       src_prio_i,
  output logic                    src_ready_o,
  input  logic                    cmd_valid_i,
  input  logic [1:0]              cmd_op_i,
  input  logic [PRIO_W+SRC_W-1:0] cmd_data_i,
  output logic                    acc_valid_o,
  output logic [PRIO_W+SRC_W-1:0] acc_data_o,
  output logic                    irq_o,
  output logic                    rej_valid_o,
  output logic [SRC_W-1:0]        rej_num_o,
  output logic                    eoi_valid_o,
  output logic [SRC_W-1:0]        eoi_num_o,
  output logic                    resend_o
);
  localparam int REG_W = PRIO_W + SRC_W;
  localparam logic [PRIO_W-1:0] PRIO_LEAST = '1;

  logic [PRIO_W-1:0] cppr_q, pend_q, mfrr_q;
  logic [SRC_W-1:0]  xisr_q;
  logic              irq_q;

  logic [PRIO_W-1:0] cppr_d, pend_d, mfrr_d;
  logic [SRC_W-1:0]  xisr_d;
  logic              irq_d;
  logic              rej_v_d, eoi_v_d, rsd_d, acc_v_d;
  logic [SRC_W-1:0]  rej_num_d, eoi_num_d;
  logic [REG_W-1:0]  acc_data_d;

  assign src_ready_o = !cmd_valid_i;

  ipc_next_state #(.SRC_W(SRC_W), .PRIO_W(PRIO_W), .IPI_NUM(IPI_NUM)) u_next (
    .cmd_valid_i(cmd_valid_i),
    .cmd_op_i   (ipc_op_e'(cmd_op_i)),
    .cmd_data_i (cmd_data_i),
    .src_valid_i(src_valid_i),
    .src_num_i  (src_num_i),
    .src_prio_i (src_prio_i),
    .cppr_i     (cppr_q),
    .xisr_i     (xisr_q),
    .pend_i     (pend_q),
    .mfrr_i     (mfrr_q),
    .irq_i      (irq_q),
    .cppr_o     (cppr_d),
    .xisr_o     (xisr_d),
    .pend_o     (pend_d),
    .mfrr_o     (mfrr_d),
    .irq_o      (irq_d),
    .rej_v_o    (rej_v_d),
    .rej_num_o  (rej_num_d),
    .eoi_v_o    (eoi_v_d),
    .eoi_num_o  (eoi_num_d),
    .resend_o   (rsd_d),
    .acc_v_o    (acc_v_d),
    .acc_data_o (acc_data_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cppr_q      <= '0;
      xisr_q      <= '0;
      pend_q      <= PRIO_LEAST;
      mfrr_q      <= PRIO_LEAST;
      irq_q       <= 1'b0;
      rej_valid_o <= 1'b0;
      rej_num_o   <= '0;
      eoi_valid_o <= 1'b0;
      eoi_num_o   <= '0;
      resend_o    <= 1'b0;
      acc_valid_o <= 1'b0;
      acc_data_o  <= '0;
    end else begin
      cppr_q      <= cppr_d;
      xisr_q      <= xisr_d;
      pend_q      <= pend_d;
      mfrr_q      <= mfrr_d;
      irq_q       <= irq_d;
      rej_valid_o <= rej_v_d;
      rej_num_o   <= rej_num_d;
      eoi_valid_o <= eoi_v_d;
      eoi_num_o   <= eoi_num_d;
      resend_o    <= rsd_d;
      acc_valid_o <= acc_v_d;
      acc_data_o  <= acc_data_d;
    end
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/ipc_checker.sv
module ipc_checker #(
  parameter int SRC_W  = 24,
  parameter int PRIO_W = 8
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    src_valid_i,
  input logic                    cmd_valid_i,
  input logic [1:0]              cmd_op_i,
  input logic [PRIO_W+SRC_W-1:0] cmd_data_i,
  input logic                    acc_valid_o,
  input logic                    irq_o,
  input logic                    rej_valid_o,
  input logic                    eoi_valid_o,
  input logic [SRC_W-1:0]        eoi_num_o,
  input logic                    resend_o
);
  AST_EOI_FORWARD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eoi_valid_o |-> ($past(cmd_valid_i) && $past(cmd_op_i) == 2'd3
                     && eoi_num_o == $past(cmd_data_i[SRC_W-1:0]))); // R7

  AST_RESEND_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resend_o |-> ($past(cmd_valid_i) && ($past(cmd_op_i) == 2'd0 || $past(cmd_op_i) == 2'd3))); // R6

  AST_ACCEPT_LOWERS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_valid_o |-> !irq_o); // R4

  AST_ACCEPT_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_valid_o |-> ($past(cmd_valid_i) && $past(cmd_op_i) == 2'd2)); // R4

  AST_IRQ_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(irq_o) |-> ($past(cmd_valid_i) && ($past(cmd_op_i) == 2'd0 || $past(cmd_op_i) == 2'd2))); // R5

  AST_IRQ_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> (($past(cmd_valid_i) && $past(cmd_op_i) != 2'd2)
                      || (!$past(cmd_valid_i) && $past(src_valid_i)))); // R3

  AST_REJECT_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rej_valid_o |-> ($past(src_valid_i) || $past(cmd_valid_i))); // R2

  AST_HELD_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rej_valid_o && $past(cmd_valid_i)) |-> ($past(cmd_op_i) != 2'd2 && $past(cmd_op_i) != 2'd3)); // R9
endmodule

bind irq_present_ctrl ipc_checker #(.SRC_W(SRC_W), .PRIO_W(PRIO_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .src_valid_i(src_valid_i),
  .cmd_valid_i(cmd_valid_i),
  .cmd_op_i   (cmd_op_i),
  .cmd_data_i (cmd_data_i),
  .acc_valid_o(acc_valid_o),
  .irq_o      (irq_o),
  .rej_valid_o(rej_valid_o),
  .eoi_valid_o(eoi_valid_o),
  .eoi_num_o  (eoi_num_o),
  .resend_o   (resend_o)
);

// File: tb/irq_present_ctrl_tb.sv
`timescale 1ns/1ps
module irq_present_ctrl_tb;
  localparam int IPI = 2;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        src_valid_i = 1'b0;
  logic [23:0] src_num_i = '0;
  logic [7:0]  src_prio_i = '0;
  logic        src_ready_o;
  logic        cmd_valid_i = 1'b0;
  logic [1:0]  cmd_op_i = '0;
  logic [31:0] cmd_data_i = '0;
  logic        acc_valid_o;
  logic [31:0] acc_data_o;
  logic        irq_o;
  logic        rej_valid_o;
  logic [23:0] rej_num_o;
  logic        eoi_valid_o;
  logic [23:0] eoi_num_o;
  logic        resend_o;

  always #5 clk_i = ~clk_i;

  irq_present_ctrl u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .src_valid_i(src_valid_i), .src_num_i(src_num_i), .src_prio_i(src_prio_i),
    .src_ready_o(src_ready_o),
    .cmd_valid_i(cmd_valid_i), .cmd_op_i(cmd_op_i), .cmd_data_i(cmd_data_i),
    .acc_valid_o(acc_valid_o), .acc_data_o(acc_data_o), .irq_o(irq_o),
    .rej_valid_o(rej_valid_o), .rej_num_o(rej_num_o),
    .eoi_valid_o(eoi_valid_o), .eoi_num_o(eoi_num_o), .resend_o(resend_o)
  );

  int checks = 0;
  int failures = 0;

  // reference model state
  logic [7:0]  m_cppr, m_pend, m_mfrr;
  logic [23:0] m_xisr;
  logic        m_irq;
  logic        e_rej, e_eoi, e_rsd, e_acc;
  logic [23:0] e_rejn, e_eoin;
  logic [31:0] e_accd;

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task m_reject(input logic [23:0] n);
    e_rej  = 1'b1;
    e_rejn = n;
  endtask

  task m_ipi_check();
    if (!(m_xisr != 0 && m_pend <= m_mfrr)) begin
      if (m_xisr != 0) m_reject(m_xisr);
      m_xisr = 24'(IPI);
      m_pend = m_mfrr;
      m_irq  = 1'b1;
    end
  endtask

  task m_resend();
    if (m_mfrr < m_cppr) m_ipi_check();
    e_rsd = 1'b1;
  endtask

  task m_step(input logic cv, input logic [1:0] op, input logic [31:0] d,
              input logic sv, input logic [23:0] sn, input logic [7:0] sp);
    logic busy;
    e_rej = 0; e_rejn = 0; e_eoi = 0; e_eoin = 0; e_rsd = 0; e_acc = 0; e_accd = 0;
    busy = (m_xisr != 0);
    if (cv) begin
      case (op)
        2'd0: begin
          if (d[7:0] < m_cppr) begin
            if (busy && d[7:0] <= m_pend) begin
              m_reject(m_xisr); m_xisr = 0; m_irq = 0;
            end
            m_cppr = d[7:0];
          end else begin
            m_cppr = d[7:0];
            if (!busy) m_resend();
          end
        end
        2'd1: begin
          m_mfrr = d[7:0];
          if (m_mfrr < m_cppr) m_ipi_check();
        end
        2'd2: begin
          e_acc = 1; e_accd = {m_cppr, m_xisr};
          m_irq = 0; m_cppr = m_pend; m_xisr = 0;
        end
        default: begin
          m_cppr = d[31:24]; e_eoi = 1; e_eoin = d[23:0];
          if (!busy) m_resend();
        end
      endcase
    end else if (sv) begin
      if (sp >= m_cppr || (busy && m_pend <= sp)) m_reject(sn);
      else begin
        if (busy) m_reject(m_xisr);
        m_xisr = sn; m_pend = sp; m_irq = 1;
      end
    end
  endtask

  // drive one cycle, advance the model, compare all outputs after the edge
  task step(input logic cv, input logic [1:0] op, input logic [31:0] d,
            input logic sv, input logic [23:0] sn, input logic [7:0] sp);
    @(negedge clk_i);
    cmd_valid_i = cv; cmd_op_i = op; cmd_data_i = d;
    src_valid_i = sv; src_num_i = sn; src_prio_i = sp;
    #1;
    chk(src_ready_o == !cv, "R9 ready", 32'(src_ready_o), 32'(!cv));
    m_step(cv, op, d, sv, sn, sp);
    @(posedge clk_i);
    #1;
    chk(irq_o == m_irq, "R3 irq", 32'(irq_o), 32'(m_irq));
    chk(rej_valid_o == e_rej, "R2 rej_valid", 32'(rej_valid_o), 32'(e_rej));
    if (e_rej) chk(rej_num_o == e_rejn, "R2 rej_num", 32'(rej_num_o), 32'(e_rejn));
    chk(eoi_valid_o == e_eoi && (!e_eoi || eoi_num_o == e_eoin), "R7 eoi",
        {7'd0, eoi_valid_o, eoi_num_o}, {7'd0, e_eoi, e_eoin});
    chk(resend_o == e_rsd, "R6 resend", 32'(resend_o), 32'(e_rsd));
    chk(acc_valid_o == e_acc, "R4 acc_valid", 32'(acc_valid_o), 32'(e_acc));
    if (e_acc) chk(acc_data_o == e_accd, "R4 acc_data", acc_data_o, e_accd);
  endtask

  task cmd(input logic [1:0] op, input logic [31:0] d);
    step(1'b1, op, d, 1'b0, 24'd0, 8'd0);
  endtask

  task deliver(input logic [23:0] n, input logic [7:0] p);
    step(1'b0, 2'd0, 32'd0, 1'b1, n, p);
  endtask

  function automatic logic [7:0] rnd_prio();
    if ($urandom_range(0, 9) == 0) return 8'hFF;
    return 8'($urandom_range(0, 15));
  endfunction

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    m_cppr = 0; m_xisr = 0; m_pend = 8'hFF; m_mfrr = 8'hFF; m_irq = 0;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    rst_ni = 1'b1;
    #1;
    // R1 reset state
    chk(!irq_o && !rej_valid_o && !eoi_valid_o && !resend_o && !acc_valid_o, "R1 idle",
        {27'd0, irq_o, rej_valid_o, eoi_valid_o, resend_o, acc_valid_o}, 32'd0);
    cmd(2'd2, 0);
    chk(acc_data_o == 32'h0000_0000, "R1 first accept", acc_data_o, 32'h0);
    cmd(2'd2, 0);
    chk(acc_data_o == 32'hFF00_0000, "R1 second accept", acc_data_o, 32'hFF00_0000);

    cmd(2'd0, 32'h10);
    deliver(24'h55, 8'd5);
    chk(irq_o == 1'b1, "R3 raise", 32'(irq_o), 32'd1);
    deliver(24'h66, 8'd3);
    chk(rej_valid_o && rej_num_o == 24'h55, "R3 displaced", 32'(rej_num_o), 32'h55);
    deliver(24'h77, 8'd3);
    chk(rej_valid_o && rej_num_o == 24'h77, "R2 equal pending", 32'(rej_num_o), 32'h77);
    deliver(24'h88, 8'h20);
    chk(rej_valid_o && rej_num_o == 24'h88, "R2 above cppr", 32'(rej_num_o), 32'h88);
    cmd(2'd2, 0);
    chk(acc_data_o == 32'h1000_0066 && !irq_o, "R4 accept word", acc_data_o, 32'h1000_0066);
    cmd(2'd3, 32'h1000_0066);
    chk(eoi_valid_o && eoi_num_o == 24'h66 && resend_o, "R7 eoi+resend", 32'(eoi_num_o), 32'h66);

    cmd(2'd1, 32'h4);
    chk(irq_o == 1'b1, "R8 ipi raise", 32'(irq_o), 32'd1);
    cmd(2'd2, 0);
    chk(acc_data_o == 32'h1000_0002, "R8 ipi number", acc_data_o, 32'h1000_0002);
    cmd(2'd3, 32'h1000_0000);
    chk(irq_o && resend_o, "R6 resend reinstalls ipi", {30'd0, irq_o, resend_o}, 32'd3);
    cmd(2'd0, 32'h2);
    chk(!irq_o && rej_valid_o && rej_num_o == 24'd2, "R5 tighten rejects", 32'(rej_num_o), 32'd2);
    cmd(2'd0, 32'h2);
    chk(resend_o && !irq_o, "R6 equal cppr resend", {30'd0, resend_o, irq_o}, 32'd2);

    cmd(2'd1, 32'hFF);
    step(1'b1, 2'd0, 32'h20, 1'b1, 24'h99, 8'd1);
    chk(!rej_valid_o && !irq_o, "R9 held off", {30'd0, rej_valid_o, irq_o}, 32'd0);
    cmd(2'd2, 0);
    chk(acc_data_o == 32'h2000_0000, "R9 delivery dropped", acc_data_o, 32'h2000_0000);

    for (int i = 0; i < 4000; i++) begin
      logic        cv, sv;
      logic [1:0]  op;
      logic [31:0] d;
      cv = ($urandom_range(0, 9) < 4);
      sv = ($urandom_range(0, 9) < 6);
      op = 2'($urandom_range(0, 3));
      d  = (op == 2'd3) ? {rnd_prio(), 24'($urandom_range(1, 300))} : {24'd0, rnd_prio()};
      step(cv, op, d, sv, 24'($urandom_range(3, 200)), rnd_prio());
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule